// File: doc/BRIEF.md
# Base-Region Chip-Select Decoder

This block drives an active-low select for one memory region whose base is pinned at address zero. The region's size is a power of two, no smaller than 4 KB and no larger than 16 MB. Software sets the size by writing a twelve-bit mask that covers address lines 23 down to 12. Each set mask bit requires the matching line to be low. Lines 31 to 24 must always be low for a memory access to hit. Clearing mask bits from line 12 upward doubles the region at each step.

Two byte-wide control registers, picked by a one-bit register select, hold the mask and a refresh-enable flag. An external master enable gates memory decodes. Refresh cycles bypass the master enable and assert the select whenever the refresh flag is set. The select is registered, so it follows the transaction inputs by one clock.

Top module: `zero_base_cs`

## Requirements
- R1: After reset, register 0 reads 0x00, register 1 reads 0x01 (only the mask bit for line 16 set), and `cs_n` is high.
- R2: Register select 0 addresses register 0, where bits 7:4 are mask bits for lines 15:12 and bit 0 is the refresh flag. Register select 1 addresses register 1, where bits 7:0 are mask bits for lines 23:16. A write strobe updates the register at the next clock edge. A read (read strobe high) returns the current contents and changes no state.
- R3: Bits 3:1 of register 0 always read as 0, whatever is written to them.
- R4: On a memory transaction with the master enable high and address bits 31:24 all zero, `cs_n` goes low one cycle later exactly when every address line in 23:12 whose mask bit is 1 is 0.
- R5: A memory transaction with any of address bits 31:24 set never asserts the select.
- R6: A memory transaction with the master enable low never asserts the select.
- R7: A refresh transaction asserts the select one cycle later when the refresh flag is 1, regardless of the master enable and the address. With the flag at 0, a refresh transaction alone leaves `cs_n` high.
- R8: `cs_n` is registered. It reflects the inputs sampled at the previous clock edge and is high after any cycle with neither transaction type.
- R9: A non-contiguous mask is applied literally, bit by bit.
- R10: With the top k mask bits set (lines 23 down to 24-k, k from 0 to 12) and the rest clear, a memory access is selected exactly when its address is below 2^(24-k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 32 | Memory address bus |
| mem_txn | input | 1 | A memory transaction is in progress this cycle |
| rfsh_txn | input | 1 | A refresh transaction is in progress this cycle |
| master_en | input | 1 | Master enable for memory decodes |
| reg_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Register read data (zero when not reading) |
| cs_n | output | 1 | Registered active-low region select |

## Verification
The bench sweeps every contiguous mask from 16 MB down to 4 KB. For each size it probes the addresses just inside and just outside the boundary, and every single-bit address. A design with a shifted or reversed mask would open the wrong window at some size. The bench then runs all 4096 patterns of lines 23:12 against a scattered mask, which catches decode that assumes contiguity. It also checks upper-byte addresses, memory cycles with the master enable off, and refresh cycles with the enable off. These catch a missing upper-byte test, a master enable wrongly applied to refresh, and a refresh flag that is ignored. Finally it reads back reserved bits after writing ones, which exposes storage that keeps bits 3:1.

// File: rtl/zbcs_pkg.sv
package zbcs_pkg;
    localparam int CS_ADDR_W  = 32;
    localparam int CS_GRAN    = 12;   // lowest decoded line (4 KB)
    localparam int CS_TOP     = 24;   // first line that must always be zero
    localparam int CS_MASK_W  = CS_TOP - CS_GRAN;
    localparam int CS_REG_W   = 8;
    localparam int CS_LO_NIB  = CS_MASK_W - CS_REG_W;  // mask bits kept in register 0
    localparam logic [CS_MASK_W-1:0] CS_MASK_RST = CS_MASK_W'(1) << CS_LO_NIB;

    typedef struct packed {
        logic [CS_MASK_W-1:0] mask;
        logic                 rfsh_en;
    } cs_cfg_t;

    typedef struct packed {
        logic cs_n;
    } cs_out_t;
endpackage

// File: rtl/zbcs_regs.sv
module zbcs_regs
    import zbcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                sel,
    input  logic [CS_REG_W-1:0] wdata,
    output logic [CS_REG_W-1:0] rdata,
    output logic [CS_MASK_W-1:0] mask,
    output logic                rfsh_en
);
    cs_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!sel) begin
                cfg_d.mask[CS_LO_NIB-1:0] = wdata[CS_REG_W-1:CS_REG_W-CS_LO_NIB];
                cfg_d.rfsh_en             = wdata[0];
            end else begin
                cfg_d.mask[CS_MASK_W-1:CS_LO_NIB] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask    <= CS_MASK_RST;
            cfg_q.rfsh_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (!sel) begin
                rdata = {cfg_q.mask[CS_LO_NIB-1:0],
                         {(CS_REG_W-CS_LO_NIB-1){1'b0}}, cfg_q.rfsh_en};
            end else begin
                rdata = cfg_q.mask[CS_MASK_W-1:CS_LO_NIB];
            end
        end
    end

    assign mask    = cfg_q.mask;
    assign rfsh_en = cfg_q.rfsh_en;

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel) |-> (rdata[3:1] == 3'b000));

    // R2
    wr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel) |=> (mask[CS_MASK_W-1:CS_LO_NIB] == $past(wdata)));

    // R2
    rd_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> ($stable(mask) && $stable(rfsh_en)));
endmodule

// File: rtl/zbcs_match.sv
module zbcs_match
    import zbcs_pkg::*;
(
    input  logic [CS_ADDR_W-1:CS_GRAN] addr_hi,
    input  logic [CS_MASK_W-1:0]       mask,
    input  logic                       mem_txn,
    input  logic                       rfsh_txn,
    input  logic                       master_en,
    input  logic                       rfsh_en,
    output logic                       hit
);
    logic [CS_MASK_W-1:0] line_fail;
    logic                 upper_clear;
    logic                 mem_hit;

    for (genvar i = 0; i < CS_MASK_W; i++) begin : g_line
        assign line_fail[i] = mask[i] & addr_hi[CS_GRAN+i];
    end

    assign upper_clear = (addr_hi[CS_ADDR_W-1:CS_TOP] == '0);
    assign mem_hit     = mem_txn & master_en & upper_clear & ~(|line_fail);
    assign hit         = mem_hit | (rfsh_txn & rfsh_en);
endmodule

// File: rtl/zero_base_cs.sv
module zero_base_cs
    import zbcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CS_ADDR_W-1:0] addr,
    input  logic                 mem_txn,
    input  logic                 rfsh_txn,
    input  logic                 master_en,
    input  logic                 reg_sel,
    input  logic [CS_REG_W-1:0]  reg_wdata,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    output logic [CS_REG_W-1:0]  reg_rdata,
    output logic                 cs_n
);
    logic [CS_MASK_W-1:0] mask;
    logic                 rfsh_en;
    logic                 hit;
    cs_out_t              out_d, out_q;

    zbcs_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .rd_en   (reg_rd),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .mask    (mask),
        .rfsh_en (rfsh_en)
    );

    zbcs_match u_match (
        .addr_hi   (addr[CS_ADDR_W-1:CS_GRAN]),
        .mask      (mask),
        .mem_txn   (mem_txn),
        .rfsh_txn  (rfsh_txn),
        .master_en (master_en),
        .rfsh_en   (rfsh_en),
        .hit       (hit)
    );

    always_comb begin
        out_d      = out_q;
        out_d.cs_n = ~hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.cs_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign cs_n = out_q.cs_n;

    // R8
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_txn && !rfsh_txn) |=> cs_n);

    // R5
    upper_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_txn && !rfsh_txn && (|addr[CS_ADDR_W-1:CS_TOP])) |=> cs_n);

    // R6
    me_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_txn && !rfsh_txn && !master_en) |=> cs_n);

    // R7
    rfsh_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_txn && rfsh_en) |=> !cs_n);
endmodule

// File: tb/zero_base_cs_tb.sv
module zero_base_cs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        mem_txn = 1'b0, rfsh_txn = 1'b0, master_en = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cs_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zero_base_cs u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_txn(mem_txn),
        .rfsh_txn(rfsh_txn), .master_en(master_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .cs_n(cs_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1;
        check(tag, {24'h0, reg_rdata}, {24'h0, exp});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_mask(input logic [11:0] m, input logic rf);
        wr_reg(1'b1, m[11:4]);
        wr_reg(1'b0, {m[3:0], 3'b000, rf});
    endtask

    // drive one transaction, check cs_n one edge later
    task automatic probe(input logic [31:0] a, input logic m, input logic r,
                         input logic e, input logic exp_sel, input string tag);
        @(negedge clk);
        addr = a; mem_txn = m; rfsh_txn = r; master_en = e;
        @(negedge clk);
        check(tag, {31'h0, cs_n}, {31'h0, ~exp_sel});
        mem_txn = 1'b0; rfsh_txn = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] mk;
        logic [31:0] a;
        logic        exp_s;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n in reset", {31'h0, cs_n}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs_n after reset", {31'h0, cs_n}, 32'h1);
        rd_check(1'b0, 8'h00, "R1 reg0 reset");
        rd_check(1'b1, 8'h01, "R1 reg1 reset");
        // R1/R4 reset decode: only line 16 tested
        probe(32'h0001_0000, 1, 0, 1, 0, "R1 reset mask line16 set");
        probe(32'h0002_F000, 1, 0, 1, 1, "R1 reset mask line16 clear");
        probe(32'h0000_0000, 1, 0, 1, 1, "R4 base address");
        // R8 idle cycle after a hit returns high
        @(negedge clk);
        check("R8 idle high", {31'h0, cs_n}, 32'h1);
        // R3 reserved bits
        wr_reg(1'b0, 8'hFF);
        rd_check(1'b0, 8'hF1, "R3 reserved read zero");
        rd_check(1'b0, 8'hF1, "R2 read has no effect");
        // R10/R2 contiguous sweep
        for (int k = 0; k <= 12; k++) begin
            logic [31:0] sz;
            mk = (k == 0) ? 12'h000 : ((12'hFFF << (12 - k)) & 12'hFFF);
            sz = 32'h1 << (24 - k);
            set_mask(mk, 1'b0);
            rd_check(1'b1, mk[11:4], "R2 reg1 readback");
            rd_check(1'b0, {mk[3:0], 4'h0}, "R2 reg0 readback");
            probe(sz - 1, 1, 0, 1, 1, "R10 last inside");
            if (k > 0) probe(sz, 1, 0, 1, 0, "R10 first outside");
            for (int b = 12; b < 24; b++) begin
                a = 32'h1 << b;
                probe(a, 1, 0, 1, (a < sz), "R10 single line");
                probe(a - 1, 1, 0, 1, ((a - 1) < sz), "R10 below line");
            end
        end
        // R5 upper byte
        set_mask(12'h000, 1'b0);
        for (int b = 24; b < 32; b++) probe(32'h1 << b, 1, 0, 1, 0, "R5 upper bit");
        probe(32'hFF00_0000, 1, 0, 1, 0, "R5 upper byte full");
        // R6 master enable off
        probe(32'h0, 1, 0, 0, 0, "R6 master off");
        // R7 refresh
        probe(32'hFFFF_FFFF, 0, 1, 0, 0, "R7 refresh flag clear");
        set_mask(12'hFFF, 1'b1);
        probe(32'hFFFF_FFFF, 0, 1, 0, 1, "R7 refresh master off");
        probe(32'h0000_0000, 0, 1, 1, 1, "R7 refresh master on");
        probe(32'h0000_0000, 0, 0, 1, 0, "R8 no txn");
        // R9 scattered mask, exhaustive over lines 23:12
        mk = 12'b1010_0000_0101;
        set_mask(mk, 1'b0);
        for (int p = 0; p < 4096; p++) begin
            exp_s = 1'b1;
            for (int i = 0; i < 12; i++) if (mk[i] && p[i]) exp_s = 1'b0;
            probe(32'(p) << 12, 1, 0, 1, exp_s, "R9 scattered mask");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule